// File: doc/BRIEF.md
# D-Channel Access Controller

This block decides when a terminal sharing a multipoint basic-rate bus may put a frame onto the D channel. While it waits, it counts how many binary ones in a row have come back on the echo channel. When that run reaches the threshold set by the current priority class and level, and layer 2 has a frame ready, the block takes the channel. It then drives the D bits that layer 2 supplies and compares each echoed bit with the bit it sent. If any echoed bit differs from the sent bit, it drops the channel at once and flags a collision. It then goes back to counting.

Two priority classes exist. Each class has a normal level and a lower level, one step apart. A terminal that has just sent a frame drops to the lower level, so the other terminals get their turn. It regains the normal level once it has seen a run of ones as long as the lower-level threshold. A 4-bit activation command picks the class, and a 4-bit indication reports that the line is active and which class is in force. Bit timing comes from two strobes supplied from outside, one for each D bit slot and one for each echo bit.

Top module: `dch_access_ctrl`

## Requirements
- R1: After reset, `dch_ready` is 0, `d_out` is 1, `collision` is 0, priority class 1 is in force at the normal level, and the ones count is 0.
- R2: A command strobe with code 4'b1000 selects class 1 and code 4'b1001 selects class 2. Any other code leaves the class unchanged.
- R3: When `line_active` is 0, `ind_code` is 4'b1111. When `line_active` is 1, `ind_code` is 4'b1100 for class 1 and 4'b1101 for class 2.
- R4: While monitoring, each echo strobe with echo bit 1 adds one to the ones count, and each echo strobe with echo bit 0 clears it. Access is granted only while `frame_pending` is 1 and the count is at least the current threshold. The grant is visible as `dch_ready` = 1 on the clock after the deciding echo strobe.
- R5: The threshold is 8 for class 1 at the normal level, 9 for class 1 at the lower level, 10 for class 2 at the normal level, and 11 for class 2 at the lower level.
- R6: While access is held, `d_out` takes the value of `tx_data` on the clock after each D strobe. Outside of access, and before the first D strobe of a frame, `d_out` is 1.
- R7: While access is held, if an echo strobe carries a bit that differs from the last sent D bit, then on the next clock `collision` is 1 for exactly one cycle, `dch_ready` falls to 0, and `d_out` returns to 1. The ones count then restarts from 0 and the priority level does not change.
- R8: If the echo matches a D bit that was marked `tx_last`, access ends on the next clock and the priority level becomes lower.
- R9: At the lower level, the level returns to normal once the ones count reaches the lower-level threshold, whether or not a frame is pending.
- R10: During access, echo strobes do not advance the ones count. After access ends, a full threshold run of ones is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stb | input | 1 | Activation command valid |
| cmd_code | input | 4 | Activation command code |
| line_active | input | 1 | Layer 1 is active (INFO 4 received) |
| ind_code | output | 4 | Activation indication with the class in force |
| frame_pending | input | 1 | Layer 2 has a frame to send |
| d_stb | input | 1 | D bit slot strobe |
| tx_data | input | 1 | Next D bit from layer 2 |
| tx_last | input | 1 | The D bit is the last bit of the frame |
| e_stb | input | 1 | Echo bit strobe |
| echo_bit | input | 1 | Received echo channel bit |
| d_out | output | 1 | D bit driven onto the line |
| dch_ready | output | 1 | D-channel access is held |
| collision | output | 1 | One-cycle pulse on collision abort |

## Verification
The hardest state to reach from the ports is the restore of the normal level. The bench first has to grant a frame, let it finish cleanly so the level drops, and then withhold `frame_pending`. In that state a run of lower-threshold ones can only restore the level and cannot grant access. The bench then breaks the run with a zero and checks that a new grant comes at the normal threshold, not the lower one. Collisions are produced by echoing the inverse of a sent bit in the middle of a frame. After each collision, the bench checks that the next grant needs a full run of ones again at the same level.

// File: rtl/dch_pkg.sv
package dch_pkg;

    // Activation request codes
    localparam logic [3:0] CMD_REQ_C1 = 4'b1000;
    localparam logic [3:0] CMD_REQ_C2 = 4'b1001;

    // Indication codes
    localparam logic [3:0] IND_ACT_C1 = 4'b1100;
    localparam logic [3:0] IND_ACT_C2 = 4'b1101;
    localparam logic [3:0] IND_IDLE   = 4'b1111;

    typedef enum logic {
        CLASS_1 = 1'b0,
        CLASS_2 = 1'b1
    } prio_class_e;

    typedef enum logic {
        LVL_NORMAL = 1'b0,
        LVL_LOWER  = 1'b1
    } prio_level_e;

    typedef enum logic {
        ST_MONITOR = 1'b0,
        ST_SEND    = 1'b1
    } ch_state_e;

endpackage

// File: rtl/dch_class_reg.sv
module dch_class_reg
    import dch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_stb,
    input  logic [3:0]  cmd_code,
    input  logic        line_active,
    output prio_class_e cls,
    output logic [3:0]  ind_code
);

    typedef struct packed {
        prio_class_e cls;
    } cls_regs_t;

    cls_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cmd_stb) begin
            if (cmd_code == CMD_REQ_C1) begin
                r_d.cls = CLASS_1;
            end else if (cmd_code == CMD_REQ_C2) begin
                r_d.cls = CLASS_2;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cls: CLASS_1};
        end else begin
            r_q <= r_d;
        end
    end

    assign cls = r_q.cls;

    always_comb begin
        if (!line_active) begin
            ind_code = IND_IDLE;
        end else if (r_q.cls == CLASS_2) begin
            ind_code = IND_ACT_C2;
        end else begin
            ind_code = IND_ACT_C1;
        end
    end

    // R2
    unknown_cmd_keeps_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_code != CMD_REQ_C1 && cmd_code != CMD_REQ_C2) |=> $stable(cls));

    // R3
    ind_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_code == IND_IDLE) || (ind_code == IND_ACT_C1) || (ind_code == IND_ACT_C2));

endmodule

// File: rtl/dch_echo_count.sv
module dch_echo_count #(
    parameter int MAX_CNT = 11,
    localparam int CNT_W  = $clog2(MAX_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             e_stb,
    input  logic             echo_bit,
    input  logic             hold,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.cnt = '0;
        end else if (e_stb && !hold) begin
            if (!echo_bit) begin
                r_d.cnt = '0;
            end else if (r_q.cnt < CNT_W'(MAX_CNT)) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign count = r_q.cnt;

    // R4
    count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX_CNT));

    // R10
    count_frozen_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clear) |=> $stable(count));

endmodule

// File: rtl/dch_access_fsm.sv
module dch_access_fsm
    import dch_pkg::*;
#(
    parameter int BASE_THR   = 8,
    parameter int CLASS_STEP = 2,
    localparam int MAX_THR   = BASE_THR + CLASS_STEP + 1,
    localparam int CNT_W     = $clog2(MAX_THR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  prio_class_e      cls,
    input  logic [CNT_W-1:0] count,
    input  logic             frame_pending,
    input  logic             d_stb,
    input  logic             tx_data,
    input  logic             tx_last,
    input  logic             e_stb,
    input  logic             echo_bit,
    output logic             count_hold,
    output logic             count_clear,
    output logic             d_out,
    output logic             dch_ready,
    output logic             collision
);

    typedef struct packed {
        ch_state_e   state;
        prio_level_e level;
        logic        d_bit;
        logic        await_echo;
        logic        last_sent;
        logic        collide;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    logic [CNT_W-1:0] thr_norm;
    logic [CNT_W-1:0] thr_low;
    logic [CNT_W-1:0] thr_now;

    always_comb begin
        thr_norm = CNT_W'(BASE_THR) + ((cls == CLASS_2) ? CNT_W'(CLASS_STEP) : '0);
        thr_low  = thr_norm + 1'b1;
        thr_now  = (r_q.level == LVL_LOWER) ? thr_low : thr_norm;
    end

    always_comb begin
        r_d         = r_q;
        r_d.collide = 1'b0;
        count_hold  = (r_q.state == ST_SEND);
        count_clear = 1'b0;

        unique case (r_q.state)
            ST_MONITOR: begin
                r_d.d_bit = 1'b1;
                if (r_q.level == LVL_LOWER && count >= thr_low) begin
                    r_d.level = LVL_NORMAL;
                end
                if (frame_pending && count >= thr_now) begin
                    r_d.state      = ST_SEND;
                    r_d.await_echo = 1'b0;
                    r_d.last_sent  = 1'b0;
                end
            end
            ST_SEND: begin
                if (e_stb && r_q.await_echo && (echo_bit != r_q.d_bit)) begin
                    r_d.state      = ST_MONITOR;
                    r_d.collide    = 1'b1;
                    r_d.d_bit      = 1'b1;
                    r_d.await_echo = 1'b0;
                    count_clear    = 1'b1;
                end else if (e_stb && r_q.await_echo && r_q.last_sent) begin
                    r_d.state      = ST_MONITOR;
                    r_d.level      = LVL_LOWER;
                    r_d.d_bit      = 1'b1;
                    r_d.await_echo = 1'b0;
                    count_clear    = 1'b1;
                end else begin
                    if (e_stb) begin
                        r_d.await_echo = 1'b0;
                    end
                    if (d_stb) begin
                        r_d.d_bit      = tx_data;
                        r_d.last_sent  = tx_last;
                        r_d.await_echo = 1'b1;
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_MONITOR, level: LVL_NORMAL, d_bit: 1'b1,
                     await_echo: 1'b0, last_sent: 1'b0, collide: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign d_out     = r_q.d_bit;
    assign dch_ready = (r_q.state == ST_SEND);
    assign collision = r_q.collide;

    // R4
    grant_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dch_ready) |-> $past(frame_pending));

    // R4
    grant_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dch_ready) |-> ($past(count) >= CNT_W'(BASE_THR)));

    // R7
    collision_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> (!dch_ready && d_out));

    // R7
    collision_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> !collision);

    // R7
    collision_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> (r_q.level == $past(r_q.level)));

endmodule

// File: rtl/dch_access_ctrl.sv
module dch_access_ctrl
    import dch_pkg::*;
#(
    parameter int BASE_THR   = 8,
    parameter int CLASS_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_stb,
    input  logic [3:0] cmd_code,
    input  logic       line_active,
    output logic [3:0] ind_code,
    input  logic       frame_pending,
    input  logic       d_stb,
    input  logic       tx_data,
    input  logic       tx_last,
    input  logic       e_stb,
    input  logic       echo_bit,
    output logic       d_out,
    output logic       dch_ready,
    output logic       collision
);

    localparam int MAX_THR = BASE_THR + CLASS_STEP + 1;
    localparam int CNT_W   = $clog2(MAX_THR + 1);

    prio_class_e      cls;
    logic [CNT_W-1:0] count;
    logic             count_hold;
    logic             count_clear;

    dch_class_reg u_class (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_stb     (cmd_stb),
        .cmd_code    (cmd_code),
        .line_active (line_active),
        .cls         (cls),
        .ind_code    (ind_code)
    );

    dch_echo_count #(.MAX_CNT(MAX_THR)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .e_stb    (e_stb),
        .echo_bit (echo_bit),
        .hold     (count_hold),
        .clear    (count_clear),
        .count    (count)
    );

    dch_access_fsm #(.BASE_THR(BASE_THR), .CLASS_STEP(CLASS_STEP)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cls           (cls),
        .count         (count),
        .frame_pending (frame_pending),
        .d_stb         (d_stb),
        .tx_data       (tx_data),
        .tx_last       (tx_last),
        .e_stb         (e_stb),
        .echo_bit      (echo_bit),
        .count_hold    (count_hold),
        .count_clear   (count_clear),
        .d_out         (d_out),
        .dch_ready     (dch_ready),
        .collision     (collision)
    );

    // R6
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dch_ready |-> d_out);

endmodule

// File: tb/dch_access_ctrl_tb.sv
module dch_access_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_stb = 1'b0;
    logic [3:0] cmd_code = 4'b0000;
    logic       line_active = 1'b0;
    logic [3:0] ind_code;
    logic       frame_pending = 1'b0;
    logic       d_stb = 1'b0;
    logic       tx_data = 1'b1;
    logic       tx_last = 1'b0;
    logic       e_stb = 1'b0;
    logic       echo_bit = 1'b1;
    logic       d_out;
    logic       dch_ready;
    logic       collision;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dch_access_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .line_active(line_active), .ind_code(ind_code), .frame_pending(frame_pending),
        .d_stb(d_stb), .tx_data(tx_data), .tx_last(tx_last), .e_stb(e_stb),
        .echo_bit(echo_bit), .d_out(d_out), .dch_ready(dch_ready), .collision(collision)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic command(input logic [3:0] code);
        @(negedge clk); cmd_stb = 1'b1; cmd_code = code;
        @(negedge clk); cmd_stb = 1'b0;
    endtask

    task automatic echo(input logic b);
        @(negedge clk); e_stb = 1'b1; echo_bit = b;
        @(negedge clk); e_stb = 1'b0; echo_bit = 1'b1;
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) echo(1'b1);
    endtask

    // sends one D bit, returns after the echo strobe clock
    task automatic send_bit(input logic data, input logic last, input logic eb);
        @(negedge clk); d_stb = 1'b1; tx_data = data; tx_last = last;
        @(negedge clk); d_stb = 1'b0; tx_last = 1'b0;
        chk("R6 d_out follows tx_data", int'(d_out), int'(data));
        echo(eb);
    endtask

    task automatic t_reset;
        chk("R1 ready after reset", int'(dch_ready), 0);
        chk("R1 d_out after reset", int'(d_out), 1);
        chk("R1 collision after reset", int'(collision), 0);
        chk("R3 idle indication", int'(ind_code), 4'b1111);
    endtask

    task automatic t_indication;
        line_active = 1'b1; idle(1);
        chk("R3 class 1 indication", int'(ind_code), 4'b1100);
        command(4'b1001);
        chk("R2 R3 class 2 selected", int'(ind_code), 4'b1101);
        command(4'b0110);
        chk("R2 unknown code ignored", int'(ind_code), 4'b1101);
        command(4'b1000);
        chk("R2 R3 class 1 selected", int'(ind_code), 4'b1100);
    endtask

    task automatic t_grant_class1;
        frame_pending = 1'b1;
        ones(5); echo(1'b0); ones(7); idle(1);
        chk("R4 zero restarts count", int'(dch_ready), 0);
        echo(1'b1); idle(1);
        chk("R5 grant at 8 class 1 normal", int'(dch_ready), 1);
        chk("R6 d_out high before first D bit", int'(d_out), 1);
        send_bit(1'b0, 1'b0, 1'b0);
        chk("R10 ready held mid-frame", int'(dch_ready), 1);
        send_bit(1'b1, 1'b0, 1'b1);
        send_bit(1'b0, 1'b1, 1'b0);
        chk("R8 access ends after last bit", int'(dch_ready), 0);
        chk("R6 d_out idle after frame", int'(d_out), 1);
    endtask

    task automatic t_demote;
        ones(8); idle(1);
        chk("R8 lower level needs 9", int'(dch_ready), 0);
        echo(1'b1); idle(1);
        chk("R5 grant at 9 class 1 lower", int'(dch_ready), 1);
        send_bit(1'b1, 1'b1, 1'b1);
        chk("R8 frame done", int'(dch_ready), 0);
    endtask

    task automatic t_restore;
        frame_pending = 1'b0;
        ones(11); idle(1);
        chk("R4 no grant without frame", int'(dch_ready), 0);
        echo(1'b0);
        frame_pending = 1'b1;
        ones(7); idle(1);
        chk("R9 below normal threshold", int'(dch_ready), 0);
        echo(1'b1); idle(1);
        chk("R9 normal level restored", int'(dch_ready), 1);
    endtask

    task automatic t_collision;
        send_bit(1'b1, 1'b0, 1'b1);
        @(negedge clk); d_stb = 1'b1; tx_data = 1'b0; tx_last = 1'b0;
        @(negedge clk); d_stb = 1'b0;
        @(negedge clk); e_stb = 1'b1; echo_bit = 1'b1;
        @(negedge clk); e_stb = 1'b0;
        chk("R7 collision pulse", int'(collision), 1);
        chk("R7 ready dropped", int'(dch_ready), 0);
        chk("R7 d_out released", int'(d_out), 1);
        idle(1);
        chk("R7 pulse lasts one cycle", int'(collision), 0);
        ones(7); idle(1);
        chk("R7 R10 count restarted", int'(dch_ready), 0);
        echo(1'b1); idle(1);
        chk("R7 level unchanged by collision", int'(dch_ready), 1);
        send_bit(1'b1, 1'b1, 1'b1);
        chk("R8 frame done after retry", int'(dch_ready), 0);
    endtask

    task automatic t_class2;
        command(4'b1001);
        ones(10); idle(1);
        chk("R5 class 2 lower needs 11", int'(dch_ready), 0);
        echo(1'b1); idle(1);
        chk("R5 grant at 11 class 2 lower", int'(dch_ready), 1);
        send_bit(1'b0, 1'b1, 1'b0);
        frame_pending = 1'b0;
        ones(11); echo(1'b0);
        frame_pending = 1'b1;
        ones(9); idle(1);
        chk("R5 class 2 normal needs 10", int'(dch_ready), 0);
        echo(1'b1); idle(1);
        chk("R5 grant at 10 class 2 normal", int'(dch_ready), 1);
        send_bit(1'b1, 1'b1, 1'b1);
        frame_pending = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_indication;
        t_grant_class1;
        t_demote;
        t_restore;
        t_collision;
        t_class2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule